// File: doc/BRIEF.md
# Remotely Commanded Block-Move Engine

This block is a DMA channel that lives on a slave card. Masters elsewhere in the system command it through eight 32-bit registers. Those registers set the source and destination addresses, the byte count, the width of each beat, the address space, whether the move runs as one burst or as separate cycles, and which side is the system bus. A semaphore register lets several masters share the channel without stepping on each other.

Once a valid start command arrives, the engine raises a bus request. It takes the grant that comes down the daisy chain and issues one abstract master beat per acknowledged cycle. On every beat it also reads or writes a zero-latency local-memory port.

When the last beat is acknowledged, the engine drops bus ownership, flags completion and raises an interrupt. It presents the programmed status/ID byte until the interrupt is acknowledged.

Top module: `blkmv_engine`

## Requirements
- R1: Reading register 7 returns 0 while the semaphore is free and marks it owned in the same cycle. Any later read of it returns 1. A write of any value to register 7 frees it.
- R2: A write to register 6 with bit 0 set starts a move only when all of these hold:
  - the engine is idle;
  - the length in register 4 is between MIN_LEN and MAX_LEN;
  - the length is a multiple of the beat size;
  - the width code (register 5 bits [2:0]) is 0 to 4;
  - the space code (bits [6:4]) is 0 to 4.
  
  Otherwise the command is ignored and the error flag (register 6 bit 2) is set. A running move is not disturbed. An accepted start clears the error and done flags.
- R3: The grant output equals the grant input whenever no request is pending. While the request is pending, the grant output is 0.
- R4: The request rises in the cycle after an accepted start. It falls, and bus busy rises, in the cycle after the grant is seen. Request and bus busy are never high together.
- R5: Width codes 0, 1, 2, 3 and 4 mean beats of 1, 2, 4, 4 (multiplexed) and 8 bytes. Each acknowledged beat advances both addresses by that size. The move takes exactly length divided by beat size beats.
- R6: Space codes 0, 1, 2, 3 and 4 select 16, 24, 32, 40 and 64-bit bus addresses. Bus address bits above the selected space are always 0, so the address wraps within the space.
- R7: In block mode (register 5 bit 8 set), the burst-start output marks the first beat and every beat whose bus address is a multiple of PAGE_BYTES. In single-cycle mode it marks every beat.
- R8: Direction is set by register 5 bit 9.
  - With bit 9 clear, the bus side reads at the source address and local memory is written at the destination with the bus data, on each acknowledged beat.
  - With bit 9 set, local memory is read at the source and its data goes out as a bus write at the destination.
- R9: In the cycle after the last acknowledged beat, the engine does all of the following:
  - bus busy and the beat valid go low;
  - done (register 6 bit 1) sets and busy (bit 0) clears;
  - the interrupt rises and holds until acknowledged, then clears one cycle after the acknowledge;
  - the status/ID output carries register 5 bits [23:16].
- R10: After reset, request, bus busy, beat valid and interrupt are low. The status register reads 0 and the semaphore is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for semaphore side effect) |
| reg_addr | input | 3 | Register index 0..7 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (same cycle) |
| bus_req | output | 1 | Bus request |
| grant_in | input | 1 | Daisy-chain grant from upstream |
| grant_out | output | 1 | Daisy-chain grant to downstream |
| bus_busy | output | 1 | Engine owns the bus |
| beat_valid | output | 1 | A master beat is presented |
| beat_ack | input | 1 | Current beat completes this cycle |
| beat_start | output | 1 | Beat opens a new burst / address phase |
| beat_blk | output | 1 | Block-transfer mode of this move |
| beat_wid | output | 3 | Width code of the beat |
| beat_spc | output | 3 | Address-space code of the beat |
| bus_addr | output | 64 | Bus address, masked to the space |
| bus_we | output | 1 | Beat is a bus write |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data |
| mem_addr | output | 64 | Local memory address |
| mem_we | output | 1 | Local memory write strobe |
| mem_wdata | output | DATA_W | Local memory write data |
| mem_rdata | input | DATA_W | Local memory read data (zero latency) |
| irq | output | 1 | Completion interrupt |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_id | output | 8 | Programmed status/ID byte |

## Verification
The bench overrides PAGE_BYTES to 64 and keeps MIN_LEN at 16 and MAX_LEN at 8 MiB. With those values, moves of 32 to 128 bytes already cross one or two burst boundaries, and the minimum length is accepted at its exact edge. The vectors cover every width code and every space code, including a 16-bit space that wraps mid-move. Directed cases cover the semaphore, each way a start command is refused, a start during a pending request, grant pass-through and the interrupt handshake.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;

    localparam int ADDR_W = 64;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_MOVE} st_e;

    typedef struct packed {
        logic [7:0] stat_id;
        logic       to_bus;
        logic       blk;
        logic [2:0] spc;
        logic [2:0] wid;
    } mode_t;

    localparam logic [2:0] RA_SRC_LO = 3'd0;
    localparam logic [2:0] RA_SRC_HI = 3'd1;
    localparam logic [2:0] RA_DST_LO = 3'd2;
    localparam logic [2:0] RA_DST_HI = 3'd3;
    localparam logic [2:0] RA_LEN    = 3'd4;
    localparam logic [2:0] RA_MODE   = 3'd5;
    localparam logic [2:0] RA_CTRL   = 3'd6;
    localparam logic [2:0] RA_SEMA   = 3'd7;

    function automatic logic [3:0] wid_bytes(input logic [2:0] c);
        case (c)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2,
            3'd3:    return 4'd4;
            3'd4:    return 4'd8;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic code_ok(input logic [2:0] c);
        return c <= 3'd4;
    endfunction

    function automatic logic [ADDR_W-1:0] spc_mask(input logic [2:0] c);
        case (c)
            3'd0:    return 64'h0000_0000_0000_FFFF;
            3'd1:    return 64'h0000_0000_00FF_FFFF;
            3'd2:    return 64'h0000_0000_FFFF_FFFF;
            3'd3:    return 64'h0000_00FF_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/blkmv_regs.sv
module blkmv_regs
    import blkmv_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              st_busy,
    input  logic              st_done,
    input  logic              st_err,
    output logic [ADDR_W-1:0] cfg_src,
    output logic [ADDR_W-1:0] cfg_dst,
    output logic [LEN_W-1:0]  cfg_len,
    output mode_t             cfg_mode,
    output logic              go_req
);

    logic sema_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_src  <= '0;
            cfg_dst  <= '0;
            cfg_len  <= '0;
            cfg_mode <= '0;
            sema_q   <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    RA_SRC_LO: cfg_src[31:0]  <= reg_wdata;
                    RA_SRC_HI: cfg_src[63:32] <= reg_wdata;
                    RA_DST_LO: cfg_dst[31:0]  <= reg_wdata;
                    RA_DST_HI: cfg_dst[63:32] <= reg_wdata;
                    RA_LEN:    cfg_len        <= reg_wdata[LEN_W-1:0];
                    RA_MODE: begin
                        cfg_mode.wid     <= reg_wdata[2:0];
                        cfg_mode.spc     <= reg_wdata[6:4];
                        cfg_mode.blk     <= reg_wdata[8];
                        cfg_mode.to_bus  <= reg_wdata[9];
                        cfg_mode.stat_id <= reg_wdata[23:16];
                    end
                    default: ;
                endcase
            end
            // R1: write frees, read of a free semaphore takes it
            if (reg_wr && reg_addr == RA_SEMA)
                sema_q <= 1'b0;
            else if (reg_rd && reg_addr == RA_SEMA)
                sema_q <= 1'b1;
        end
    end

    assign go_req = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[0];

    always_comb begin
        case (reg_addr)
            RA_SRC_LO: reg_rdata = cfg_src[31:0];
            RA_SRC_HI: reg_rdata = cfg_src[63:32];
            RA_DST_LO: reg_rdata = cfg_dst[31:0];
            RA_DST_HI: reg_rdata = cfg_dst[63:32];
            RA_LEN:    reg_rdata = {{(32-LEN_W){1'b0}}, cfg_len};
            RA_MODE:   reg_rdata = {8'b0, cfg_mode.stat_id, 6'b0, cfg_mode.to_bus,
                                    cfg_mode.blk, 1'b0, cfg_mode.spc, 1'b0, cfg_mode.wid};
            RA_CTRL:   reg_rdata = {29'b0, st_err, st_done, st_busy};
            default:   reg_rdata = {31'b0, sema_q};
        endcase
    end

    p_sema_take_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == RA_SEMA) |=> sema_q);
    p_sema_free_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_SEMA) |=> !sema_q);

endmodule

// File: rtl/blkmv_arb.sv
module blkmv_arb (
    input  logic want,
    input  logic grant_in,
    output logic bus_req,
    output logic grant_out,
    output logic grant_take
);
    // R3: grant passes through unless a request is pending, then it is absorbed
    assign bus_req    = want;
    assign grant_out  = grant_in & ~want;
    assign grant_take = grant_in & want;
endmodule

// File: rtl/blkmv_seq.sv
module blkmv_seq
    import blkmv_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int DATA_W     = 64,
    parameter int MIN_LEN    = 16,
    parameter int MAX_LEN    = 8388608,
    parameter int PAGE_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [LEN_W-1:0]  cfg_len,
    input  mode_t             cfg_mode,
    input  logic              go_req,
    input  logic              grant_take,
    output st_e               state,
    output logic              st_busy,
    output logic              st_done,
    output logic              st_err,
    input  logic              beat_ack,
    output logic              beat_valid,
    output logic              beat_start,
    output logic              beat_blk,
    output logic [2:0]        beat_wid,
    output logic [2:0]        beat_spc,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              irq,
    input  logic              irq_ack,
    output logic [7:0]        irq_id
);

    localparam int PG_LOG = $clog2(PAGE_BYTES);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

    mode_t             act;
    logic [ADDR_W-1:0] cur_bus, cur_mem;
    logic [LEN_W-1:0]  left;
    logic              first;
    logic [3:0]        sz, new_sz;
    logic              go_ok, last_beat;

    assign sz     = wid_bytes(act.wid);
    assign new_sz = wid_bytes(cfg_mode.wid);

    // R2: start qualification
    assign go_ok = (state == ST_IDLE) && code_ok(cfg_mode.wid) && code_ok(cfg_mode.spc)
                && (cfg_len >= MIN_L) && (cfg_len <= MAX_L)
                && ((cfg_len & LEN_W'(new_sz - 4'd1)) == '0);

    assign last_beat = beat_valid && beat_ack && (left == LEN_W'(sz));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            act     <= '0;
            cur_bus <= '0;
            cur_mem <= '0;
            left    <= '0;
            first   <= 1'b0;
            st_done <= 1'b0;
            st_err  <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (irq && irq_ack) irq <= 1'b0;
            if (go_req) begin
                if (go_ok) begin
                    state   <= ST_REQ;
                    act     <= cfg_mode;
                    cur_bus <= cfg_mode.to_bus ? cfg_dst : cfg_src;
                    cur_mem <= cfg_mode.to_bus ? cfg_src : cfg_dst;
                    left    <= cfg_len;
                    first   <= 1'b1;
                    st_done <= 1'b0;
                    st_err  <= 1'b0;
                end else begin
                    st_err  <= 1'b1;
                end
            end
            case (state)
                ST_REQ: if (grant_take) state <= ST_MOVE;
                ST_MOVE: if (beat_ack) begin
                    cur_bus <= cur_bus + ADDR_W'(sz);
                    cur_mem <= cur_mem + ADDR_W'(sz);
                    left    <= left - LEN_W'(sz);
                    first   <= 1'b0;
                    if (last_beat) begin
                        state   <= ST_IDLE;
                        st_done <= 1'b1;
                        irq     <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign st_busy    = (state != ST_IDLE);
    assign beat_valid = (state == ST_MOVE);
    assign bus_addr   = cur_bus & spc_mask(act.spc);
    assign beat_start = beat_valid && (!act.blk || first || bus_addr[PG_LOG-1:0] == '0);
    assign beat_blk   = act.blk;
    assign beat_wid   = act.wid;
    assign beat_spc   = act.spc;
    assign bus_we     = beat_valid && act.to_bus;
    assign bus_wdata  = mem_rdata;
    assign mem_addr   = cur_mem;
    assign mem_we     = beat_valid && beat_ack && !act.to_bus;
    assign mem_wdata  = bus_rdata;
    assign irq_id     = act.stat_id;

    p_busy_go_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (go_req && beat_valid && !last_beat) |=> (st_err && beat_valid));
    p_space_mask_r6: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> ((bus_addr & ~spc_mask(beat_spc)) == '0));
    p_page_start_r7: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_blk && bus_addr[PG_LOG-1:0] == '0) |-> beat_start);
    p_end_irq_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(beat_valid) |-> (irq && st_done && !st_busy));
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack) |=> irq);

endmodule

// File: rtl/blkmv_engine.sv
module blkmv_engine
    import blkmv_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int DATA_W     = 64,
    parameter int MIN_LEN    = 16,
    parameter int MAX_LEN    = 8388608,
    parameter int PAGE_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              bus_req,
    input  logic              grant_in,
    output logic              grant_out,
    output logic              bus_busy,
    output logic              beat_valid,
    input  logic              beat_ack,
    output logic              beat_start,
    output logic              beat_blk,
    output logic [2:0]        beat_wid,
    output logic [2:0]        beat_spc,
    output logic [63:0]       bus_addr,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [63:0]       mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              irq,
    input  logic              irq_ack,
    output logic [7:0]        irq_id
);

    logic [ADDR_W-1:0] cfg_src, cfg_dst;
    logic [LEN_W-1:0]  cfg_len;
    mode_t             cfg_mode;
    logic              go_req, grant_take, st_busy, st_done, st_err;
    st_e               state;

    blkmv_regs #(.LEN_W(LEN_W)) u_regs (
        .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
        .st_busy, .st_done, .st_err,
        .cfg_src, .cfg_dst, .cfg_len, .cfg_mode, .go_req
    );

    blkmv_arb u_arb (
        .want(state == ST_REQ), .grant_in, .bus_req, .grant_out, .grant_take
    );

    blkmv_seq #(
        .LEN_W(LEN_W), .DATA_W(DATA_W), .MIN_LEN(MIN_LEN),
        .MAX_LEN(MAX_LEN), .PAGE_BYTES(PAGE_BYTES)
    ) u_seq (
        .clk, .rst, .cfg_src, .cfg_dst, .cfg_len, .cfg_mode, .go_req, .grant_take,
        .state, .st_busy, .st_done, .st_err,
        .beat_ack, .beat_valid, .beat_start, .beat_blk, .beat_wid, .beat_spc,
        .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
        .mem_addr, .mem_we, .mem_wdata, .mem_rdata,
        .irq, .irq_ack, .irq_id
    );

    assign bus_busy = beat_valid;

    p_req_busy_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && bus_busy));
    p_grant_taken_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && grant_in) |=> (bus_busy && !bus_req));
    p_grant_block_r3: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !grant_out);

endmodule

// File: tb/blkmv_engine_tb_top.sv
module blkmv_engine_tb_top;

    localparam int DW = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          reg_wr = 0, reg_rd = 0;
    logic [2:0]    reg_addr = 0;
    logic [31:0]   reg_wdata = 0, reg_rdata;
    logic          bus_req, grant_in = 0, grant_out, bus_busy;
    logic          beat_valid, beat_ack = 0, beat_start, beat_blk;
    logic [2:0]    beat_wid, beat_spc;
    logic [63:0]   bus_addr, mem_addr;
    logic          bus_we, mem_we;
    logic [DW-1:0] bus_wdata, bus_rdata, mem_wdata, mem_rdata;
    logic          irq, irq_ack = 0;
    logic [7:0]    irq_id;

    // data patterns seen by the engine
    always_comb bus_rdata = {bus_addr[31:0], ~bus_addr[31:0]};
    always_comb mem_rdata = {~mem_addr[31:0], mem_addr[31:0]};

    blkmv_engine #(.PAGE_BYTES(64)) dut_i (
        .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
        .bus_req, .grant_in, .grant_out, .bus_busy,
        .beat_valid, .beat_ack, .beat_start, .beat_blk, .beat_wid, .beat_spc,
        .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
        .mem_addr, .mem_we, .mem_wdata, .mem_rdata,
        .irq, .irq_ack, .irq_id
    );

    typedef struct packed {
        logic [63:0] src;
        logic [63:0] dst;
        logic [23:0] len;
        logic [2:0]  wid;
        logic [2:0]  spc;
        logic        blk;
        logic        tobus;
        logic [7:0]  id;
        logic [15:0] beats;
        logic [15:0] starts;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{64'h0000_0000_0000_1000, 64'h0000_0000_0000_0040, 24'd16,  3'd0, 3'd2, 1'b0, 1'b0, 8'h11, 16'd16, 16'd16},
        '{64'h0000_0000_0000_0100, 64'h0000_0000_0000_2030, 24'd64,  3'd2, 3'd1, 1'b1, 1'b1, 8'h22, 16'd16, 16'd2},
        '{64'hABCD_0000_0000_0038, 64'h0000_0000_0000_0800, 24'd128, 3'd4, 3'd4, 1'b1, 1'b0, 8'h33, 16'd16, 16'd3},
        '{64'hFFFF_0000_1234_FFF8, 64'h0000_0000_0000_0200, 24'd16,  3'd1, 3'd0, 1'b0, 1'b0, 8'h44, 16'd8,  16'd8},
        '{64'h0000_0000_0000_0300, 64'h0000_FF12_3456_7FF0, 24'd32,  3'd3, 3'd3, 1'b1, 1'b1, 8'h55, 16'd8,  16'd2}
    };

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] bmask(input logic [2:0] s);
        case (s)
            3'd0: return 64'hFFFF;
            3'd1: return 64'hFF_FFFF;
            3'd2: return 64'hFFFF_FFFF;
            3'd3: return 64'hFF_FFFF_FFFF;
            default: return '1;
        endcase
    endfunction

    function automatic int bsize(input logic [2:0] w);
        case (w)
            3'd0: return 1;
            3'd1: return 2;
            3'd4: return 8;
            default: return 4;
        endcase
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic program_go(input vec_t v);
        wr(3'd0, v.src[31:0]); wr(3'd1, v.src[63:32]);
        wr(3'd2, v.dst[31:0]); wr(3'd3, v.dst[63:32]);
        wr(3'd4, {8'b0, v.len});
        wr(3'd5, {8'b0, v.id, 6'b0, v.tobus, v.blk, 1'b0, v.spc, 1'b0, v.wid});
        wr(3'd6, 32'h1);
    endtask

    task automatic finish_move(input vec_t v);
        logic [63:0] bb, mb, eb, em;
        logic [31:0] st;
        int sz, starts;
        sz = bsize(v.wid);
        bb = v.tobus ? v.dst : v.src;
        mb = v.tobus ? v.src : v.dst;
        starts = 0;
        chk(bus_req == 1, "R4 request pending", 64'(bus_req), 1);
        grant_in = 1; beat_ack = 1;
        #1 chk(grant_out == 0, "R3 grant absorbed", 64'(grant_out), 0);
        for (int i = 0; i < int'(v.beats); i++) begin
            @(negedge clk);
            grant_in = 0;
            eb = (bb + 64'(i * sz)) & bmask(v.spc);
            em = mb + 64'(i * sz);
            chk(beat_valid == 1, "R5 beat valid", 64'(beat_valid), 1);
            if (i == 0) begin
                chk(bus_busy == 1 && bus_req == 0, "R4 busy after grant",
                    {62'b0, bus_busy, bus_req}, 64'h2);
                chk(beat_blk == v.blk && beat_wid == v.wid && beat_spc == v.spc, "R7 beat mode",
                    {56'b0, beat_blk, beat_wid, beat_spc, 1'b0}, {56'b0, v.blk, v.wid, v.spc, 1'b0});
            end
            chk(bus_addr == eb, "R6 bus address", bus_addr, eb);
            chk(mem_addr == em, "R5 mem address", mem_addr, em);
            if (beat_start) starts++;
            if (v.tobus) begin
                chk(bus_we == 1 && mem_we == 0, "R8 bus write", {62'b0, bus_we, mem_we}, 64'h2);
                chk(bus_wdata == {~em[31:0], em[31:0]}, "R8 bus wdata", bus_wdata, {~em[31:0], em[31:0]});
            end else begin
                chk(bus_we == 0 && mem_we == 1, "R8 mem write", {62'b0, bus_we, mem_we}, 64'h1);
                chk(mem_wdata == {eb[31:0], ~eb[31:0]}, "R8 mem wdata", mem_wdata, {eb[31:0], ~eb[31:0]});
            end
        end
        @(negedge clk);
        beat_ack = 0;
        chk(beat_valid == 0 && bus_busy == 0, "R9 bus released", {62'b0, beat_valid, bus_busy}, 0);
        chk(irq == 1, "R9 irq raised", 64'(irq), 1);
        chk(irq_id == v.id, "R9 status id", 64'(irq_id), 64'(v.id));
        chk(starts == int'(v.starts), "R7 burst starts", 64'(starts), 64'(v.starts));
        rd(3'd6, st);
        chk(st[1:0] == 2'b10, "R9 done status", 64'(st), 64'h2);
        chk(irq == 1, "R9 irq held", 64'(irq), 1);
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
        chk(irq == 0, "R9 irq cleared", 64'(irq), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        vec_t v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        chk(bus_req == 0 && bus_busy == 0 && beat_valid == 0 && irq == 0, "R10 reset outputs",
            {60'b0, bus_req, bus_busy, beat_valid, irq}, 0);
        rd(3'd6, d); chk(d == 0, "R10 status zero", 64'(d), 0);
        // R3 pass-through while idle
        grant_in = 1;
        #1 chk(grant_out == 1, "R3 grant passes idle", 64'(grant_out), 1);
        @(negedge clk); grant_in = 0;
        #1 chk(grant_out == 0, "R3 grant follows low", 64'(grant_out), 0);
        // R1 semaphore
        rd(3'd7, d); chk(d == 0, "R1 first read free", 64'(d), 0);
        rd(3'd7, d); chk(d == 1, "R1 second read owned", 64'(d), 1);
        rd(3'd7, d); chk(d == 1, "R1 stays owned", 64'(d), 1);
        wr(3'd7, 32'h0);
        rd(3'd7, d); chk(d == 0, "R1 released then free", 64'(d), 0);
        wr(3'd7, 32'h0);
        // R2 refused starts
        v = VECS[0]; v.len = 24'd8;
        program_go(v);
        rd(3'd6, d); chk(d == 32'h4, "R2 short length refused", 64'(d), 4);
        chk(bus_req == 0, "R2 no request", 64'(bus_req), 0);
        v = VECS[1]; v.len = 24'd18;
        program_go(v);
        rd(3'd6, d); chk(d == 32'h4, "R2 unaligned length refused", 64'(d), 4);
        v = VECS[0]; v.wid = 3'd5;
        program_go(v);
        rd(3'd6, d); chk(d == 32'h4, "R2 bad width refused", 64'(d), 4);
        v = VECS[0]; v.spc = 3'd6;
        program_go(v);
        rd(3'd6, d); chk(d == 32'h4, "R2 bad space refused", 64'(d), 4);
        v = VECS[0]; v.len = 24'h80_0001;
        program_go(v);
        rd(3'd6, d); chk(d == 32'h4, "R2 over-max refused", 64'(d), 4);
        chk(beat_valid == 0, "R2 no beats", 64'(beat_valid), 0);
        // vector table: R5 R6 R7 R8 R9
        for (int k = 0; k < 5; k++) begin
            program_go(VECS[k]);
            rd(3'd6, d); chk(d == 32'h1, "R2 accepted busy", 64'(d), 1);
            finish_move(VECS[k]);
        end
        // R2 start while pending request is ignored
        program_go(VECS[3]);
        wr(3'd6, 32'h1);
        rd(3'd6, d); chk(d == 32'h5, "R2 go while busy sets err", 64'(d), 5);
        finish_move(VECS[3]);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule